// File: doc/BRIEF.md
# Switch-on-Miss Thread Parking Buffer

This block assists a multithreaded in-order core that changes threads when a memory access misses. Each hardware thread owns one parking slot. When a stage reports that an instruction's request failed because of a memory stall, and the switch-on-miss mode is on, the instruction is captured in its thread's slot. In the following cycle the block squashes that thread, with the parked instruction's own sequence number as the squash point. It also pulses a suspend request for the thread and a request to wake the next ready thread.

When the scheduler later reactivates a thread whose slot is occupied, the block hands the parked instruction back for insertion at the tail of that thread's stage buffer. It raises a PC-update request so fetch resumes after that instruction, clears the slot and advances a context-switch counter. A reactivation of a thread with an empty slot does nothing.

A branch-style squash from the stage may arrive in the same cycle as a miss-driven squash. The block resolves the two and publishes the squash points in force this cycle. It also tells the forwarding logic whether a candidate instruction is younger than such a point and must be held back.

Top module: `thread_park_buffer`

## Requirements
- R1: After a synchronous active-low reset, every valid, pulse and data output is 0 and the context-switch count is 0.
- R2: A miss (miss_valid high) is parked only when mode_switch_on_miss is high. One cycle after a parked miss, suspend_valid and activate_next each pulse for one cycle, with suspend_tid equal to the miss thread. Without a parked miss both stay low.
- R3: One cycle after a parked miss, squash_valid has the bit of the miss thread set, and that thread's squash_seq lane equals the miss sequence number. A thread with no squash has its bit clear and its lane 0.
- R4: Reactivating a thread with an occupied slot produces, one cycle later, reinsert_valid and pc_update_valid high, with reinsert_tid, reinsert_inst and reinsert_seq taken from the slot. The slot is then empty. If the same thread misses in that same cycle, the new miss refills the slot.
- R5: Reactivating a thread with an empty slot gives reinsert_valid and pc_update_valid low one cycle later; all reinsert data outputs are then 0.
- R6: A stage squash (br_valid) is dropped when a parked miss of the same thread arrives in the same cycle and the miss sequence number is smaller than br_seq. Otherwise it sets that thread's squash one cycle later with squash point br_point, and it overrides a same-thread miss squash.
- R7: fwd_allow is combinational. It is high when fwd_valid is high, unless a squash is in force this cycle for fwd_tid (per R3/R6) and fwd_seq is strictly greater than that squash point.
- R8: ctx_switch_count rises by exactly one on the cycle each reinsertion appears and is otherwise unchanged.
- R9: squash_to_next, registered one cycle, equals next_stage_present. A value of 1 directs the squash at the following stage, 0 at this stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_switch_on_miss | input | 1 | Enables parking on memory-stall misses |
| next_stage_present | input | 1 | A following stage exists |
| miss_valid | input | 1 | A failed request flagged as memory stall |
| miss_tid | input | 2 | Thread of the missing instruction |
| miss_seq | input | 16 | Sequence number of the missing instruction |
| miss_inst | input | 32 | Instruction payload to park |
| react_valid | input | 1 | Thread reactivation |
| react_tid | input | 2 | Thread being reactivated |
| br_valid | input | 1 | Stage-originated squash request |
| br_tid | input | 2 | Thread of the squash request |
| br_seq | input | 16 | Sequence number of the requesting instruction |
| br_point | input | 16 | Squash point of the request |
| fwd_valid | input | 1 | Forwarding candidate present |
| fwd_tid | input | 2 | Candidate thread |
| fwd_seq | input | 16 | Candidate sequence number |
| fwd_allow | output | 1 | Candidate may go to the next stage |
| squash_valid | output | 4 | Per-thread squash pulse |
| squash_seq | output | 64 | Per-thread squash point, 16 bits per thread, thread 0 lowest |
| squash_to_next | output | 1 | Squash directed at next stage |
| suspend_valid | output | 1 | Suspend pulse |
| suspend_tid | output | 2 | Thread to suspend |
| activate_next | output | 1 | Wake next ready thread |
| reinsert_valid | output | 1 | Parked instruction returned |
| reinsert_tid | output | 2 | Thread of returned instruction |
| reinsert_inst | output | 32 | Returned instruction payload |
| reinsert_seq | output | 16 | Returned sequence number |
| pc_update_valid | output | 1 | Request fetch to resume after reinsert_seq |
| ctx_switch_count | output | 16 | Successful reinsertions |

## Verification
A slot whose occupancy is wrong shows at the ports the first time its thread is reactivated. A stuck-full slot yields a second reinsertion of stale data. A slot that never fills gives a missing reinsert pulse and a counter that does not move. Both appear one cycle after the reactivation. Faults in the duplicate-squash resolution show in the same cycle on fwd_allow and one cycle later on the squash lanes. The bench therefore compares every output each cycle against a behavioural model, with long random runs that reuse small sequence ranges so same-thread collisions are frequent.

// File: rtl/tpb_pkg.sv
// Shared widths, types and sequence-number comparison for the parking buffer.
// Assumes sequence numbers do not wrap within the lifetime of a squash window.
package tpb_pkg;
    parameter int SEQ_W = 16;
    typedef logic [SEQ_W-1:0] seq_t;

    // True when sequence number a is younger (issued later) than b.
    function automatic logic is_younger(input seq_t a, input seq_t b);
        return a > b;
    endfunction
endpackage

// File: rtl/tpb_park_slot.sv
// One parking register for a single thread. A park write has priority over
// a take (reactivation) in the same cycle. Assumes the caller only takes
// when it has read the held contents in that same cycle.
module tpb_park_slot #(
    parameter int INST_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 park_we,
    input  logic [INST_W-1:0]    park_inst,
    input  tpb_pkg::seq_t        park_seq,
    input  logic                 take,
    output logic                 occupied,
    output logic [INST_W-1:0]    held_inst,
    output tpb_pkg::seq_t        held_seq
);
    // Slot update: load on park, clear on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occupied  <= 1'b0;
            held_inst <= '0;
            held_seq  <= '0;
        end else if (park_we) begin
            occupied  <= 1'b1;
            held_inst <= park_inst;
            held_seq  <= park_seq;
        end else if (take) begin
            occupied  <= 1'b0;
        end
    end

    a_r2_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
        park_we |=> occupied);
    a_r4_slot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !park_we) |=> !occupied);
endmodule

// File: rtl/tpb_squash_filter.sv
// Combines the miss-driven squash and a stage squash arriving in one cycle,
// drops a younger duplicate on the same thread, and decides whether a
// forwarding candidate lies beyond a squash point in force this cycle.
// Purely combinational; assumes at most one of each source per cycle.
module tpb_squash_filter #(
    parameter int NTHR  = 4,
    parameter int TID_W = 2
) (
    input  logic                          miss_acc,
    input  logic [TID_W-1:0]              miss_tid,
    input  tpb_pkg::seq_t                 miss_seq,
    input  logic                          br_valid,
    input  logic [TID_W-1:0]              br_tid,
    input  tpb_pkg::seq_t                 br_seq,
    input  tpb_pkg::seq_t                 br_point,
    input  logic                          fwd_valid,
    input  logic [TID_W-1:0]              fwd_tid,
    input  tpb_pkg::seq_t                 fwd_seq,
    output logic [NTHR-1:0]               sq_now,
    output tpb_pkg::seq_t [NTHR-1:0]      sq_pt,
    output logic                          fwd_allow
);
    import tpb_pkg::*;

    logic br_dropped;

    // Drop a stage squash made redundant by an older same-thread miss squash.
    always_comb begin
        br_dropped = miss_acc && br_valid && (br_tid == miss_tid)
                     && is_younger(br_seq, miss_seq);
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        // Per-thread squash point in force this cycle; stage squash wins.
        always_comb begin
            sq_now[t] = 1'b0;
            sq_pt[t]  = '0;
            if (br_valid && !br_dropped && br_tid == TID_W'(t)) begin
                sq_now[t] = 1'b1;
                sq_pt[t]  = br_point;
            end else if (miss_acc && miss_tid == TID_W'(t)) begin
                sq_now[t] = 1'b1;
                sq_pt[t]  = miss_seq;
            end
        end
    end

    // Hold back candidates younger than this cycle's squash point.
    always_comb begin
        fwd_allow = fwd_valid &&
                    !(sq_now[fwd_tid] && is_younger(fwd_seq, sq_pt[fwd_tid]));
    end
endmodule

// File: rtl/thread_park_buffer.sv
// Top of the switch-on-miss parking buffer. Parks a missing instruction per
// thread, emits squash/suspend/wake pulses one cycle later, and returns the
// parked instruction with a PC-update request on reactivation.
// Assumes at most one miss and one reactivation per cycle.
module thread_park_buffer #(
    parameter int NTHR   = 4,
    parameter int INST_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mode_switch_on_miss,
    input  logic                              next_stage_present,
    input  logic                              miss_valid,
    input  logic [$clog2(NTHR)-1:0]           miss_tid,
    input  logic [tpb_pkg::SEQ_W-1:0]         miss_seq,
    input  logic [INST_W-1:0]                 miss_inst,
    input  logic                              react_valid,
    input  logic [$clog2(NTHR)-1:0]           react_tid,
    input  logic                              br_valid,
    input  logic [$clog2(NTHR)-1:0]           br_tid,
    input  logic [tpb_pkg::SEQ_W-1:0]         br_seq,
    input  logic [tpb_pkg::SEQ_W-1:0]         br_point,
    input  logic                              fwd_valid,
    input  logic [$clog2(NTHR)-1:0]           fwd_tid,
    input  logic [tpb_pkg::SEQ_W-1:0]         fwd_seq,
    output logic                              fwd_allow,
    output logic [NTHR-1:0]                   squash_valid,
    output logic [NTHR*tpb_pkg::SEQ_W-1:0]    squash_seq,
    output logic                              squash_to_next,
    output logic                              suspend_valid,
    output logic [$clog2(NTHR)-1:0]           suspend_tid,
    output logic                              activate_next,
    output logic                              reinsert_valid,
    output logic [$clog2(NTHR)-1:0]           reinsert_tid,
    output logic [INST_W-1:0]                 reinsert_inst,
    output logic [tpb_pkg::SEQ_W-1:0]         reinsert_seq,
    output logic                              pc_update_valid,
    output logic [CNT_W-1:0]                  ctx_switch_count
);
    import tpb_pkg::*;

    localparam int TID_W = $clog2(NTHR);

    logic                     miss_acc;
    logic [NTHR-1:0]          occ;
    logic [NTHR-1:0][INST_W-1:0] h_inst;
    seq_t [NTHR-1:0]          h_seq;
    logic [NTHR-1:0]          sq_now;
    seq_t [NTHR-1:0]          sq_pt;
    logic                     hit;

    // Parking is allowed only in switch-on-miss mode.
    always_comb miss_acc = mode_switch_on_miss && miss_valid;
    // Reactivation finds something to return.
    always_comb hit = react_valid && occ[react_tid];

    for (genvar t = 0; t < NTHR; t++) begin : g_slot
        tpb_park_slot #(.INST_W(INST_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .park_we   (miss_acc && miss_tid == TID_W'(t)),
            .park_inst (miss_inst),
            .park_seq  (miss_seq),
            .take      (react_valid && react_tid == TID_W'(t)),
            .occupied  (occ[t]),
            .held_inst (h_inst[t]),
            .held_seq  (h_seq[t])
        );
    end

    tpb_squash_filter #(.NTHR(NTHR), .TID_W(TID_W)) u_filt (
        .miss_acc  (miss_acc),
        .miss_tid  (miss_tid),
        .miss_seq  (miss_seq),
        .br_valid  (br_valid),
        .br_tid    (br_tid),
        .br_seq    (br_seq),
        .br_point  (br_point),
        .fwd_valid (fwd_valid),
        .fwd_tid   (fwd_tid),
        .fwd_seq   (fwd_seq),
        .sq_now    (sq_now),
        .sq_pt     (sq_pt),
        .fwd_allow (fwd_allow)
    );

    // Register squash, suspend and wake pulses one cycle after the cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_valid   <= '0;
            squash_seq     <= '0;
            squash_to_next <= 1'b0;
            suspend_valid  <= 1'b0;
            suspend_tid    <= '0;
            activate_next  <= 1'b0;
        end else begin
            squash_valid   <= sq_now;
            squash_seq     <= sq_pt;
            squash_to_next <= next_stage_present;
            suspend_valid  <= miss_acc;
            suspend_tid    <= miss_acc ? miss_tid : '0;
            activate_next  <= miss_acc;
        end
    end

    // Return the parked instruction and count the context switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reinsert_valid   <= 1'b0;
            reinsert_tid     <= '0;
            reinsert_inst    <= '0;
            reinsert_seq     <= '0;
            pc_update_valid  <= 1'b0;
            ctx_switch_count <= '0;
        end else begin
            reinsert_valid   <= hit;
            pc_update_valid  <= hit;
            reinsert_tid     <= hit ? react_tid : '0;
            reinsert_inst    <= hit ? h_inst[react_tid] : '0;
            reinsert_seq     <= hit ? h_seq[react_tid] : '0;
            ctx_switch_count <= ctx_switch_count + CNT_W'(hit);
        end
    end

    a_r2_suspend_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_switch_on_miss && miss_valid) |=>
            (suspend_valid && activate_next && suspend_tid == $past(miss_tid)));
    a_r2_quiet_without_park: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_switch_on_miss && miss_valid) |=> (!suspend_valid && !activate_next));
    a_r4_reinsert_needs_react: assert property (@(posedge clk) disable iff (!rst_n)
        !react_valid |=> !reinsert_valid);
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        reinsert_valid |-> ctx_switch_count == $past(ctx_switch_count) + CNT_W'(1));
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reinsert_valid |-> $stable(ctx_switch_count));
endmodule

// File: tb/sim_thread_park_buffer.sv
`timescale 1ns/1ps
module sim_thread_park_buffer;
    logic clk = 0, rst_n = 0;
    always #2 clk = ~clk;

    logic en = 0, nsp = 0, mv = 0, rv = 0, bv = 0, fv = 0;
    logic [1:0] mt = 0, rt = 0, bt = 0, ft = 0;
    logic [15:0] ms = 0, bs = 0, bp = 0, fs = 0;
    logic [31:0] mi = 0;
    logic fwd_allow, sq_next, susp, act, reins, pcu;
    logic [3:0] sqv;
    logic [63:0] sqs;
    logic [1:0] stid, rtid;
    logic [31:0] rinst;
    logic [15:0] rseq, cnt;

    thread_park_buffer u0 (
        .clk(clk), .rst_n(rst_n), .mode_switch_on_miss(en), .next_stage_present(nsp),
        .miss_valid(mv), .miss_tid(mt), .miss_seq(ms), .miss_inst(mi),
        .react_valid(rv), .react_tid(rt), .br_valid(bv), .br_tid(bt), .br_seq(bs),
        .br_point(bp), .fwd_valid(fv), .fwd_tid(ft), .fwd_seq(fs), .fwd_allow(fwd_allow),
        .squash_valid(sqv), .squash_seq(sqs), .squash_to_next(sq_next),
        .suspend_valid(susp), .suspend_tid(stid), .activate_next(act),
        .reinsert_valid(reins), .reinsert_tid(rtid), .reinsert_inst(rinst),
        .reinsert_seq(rseq), .pc_update_valid(pcu), .ctx_switch_count(cnt));

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(string tag, logic [63:0] act_v, logic [63:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    // Behavioural model state
    bit pv[4];
    logic [31:0] pi[4];
    logic [15:0] ps[4];
    int mcnt = 0;
    // Expected registered outputs for the next sample
    bit e_susp, e_act, e_rv, e_next;
    logic [1:0] e_stid, e_rtid;
    logic [31:0] e_ri;
    logic [15:0] e_rs;
    bit e_sqv[4];
    logic [15:0] e_sqp[4];

    task automatic compare_regs();
        chk("R2 suspend_valid", susp, e_susp);
        chk("R2 activate_next", act, e_act);
        chk("R2 suspend_tid", stid, e_stid);
        chk("R9 squash_to_next", sq_next, e_next);
        for (int t = 0; t < 4; t++) begin
            chk("R3/R6 squash_valid", sqv[t], e_sqv[t]);
            chk("R3/R6 squash_seq", sqs[t*16 +: 16], e_sqp[t]);
        end
        chk(e_rv ? "R4 reinsert_valid" : "R5 reinsert_valid", reins, e_rv);
        chk(e_rv ? "R4 pc_update_valid" : "R5 pc_update_valid", pcu, e_rv);
        chk("R4 reinsert_tid", rtid, e_rtid);
        chk("R4 reinsert_inst", rinst, e_ri);
        chk("R4 reinsert_seq", rseq, e_rs);
        chk("R8 ctx_switch_count", cnt, mcnt);
    endtask

    // One model step from the inputs currently driven.
    task automatic model_step();
        bit macc, drop, hit;
        bit nv[4];
        logic [15:0] np[4];
        macc = en && mv;
        drop = macc && bv && bt == mt && bs > ms;
        for (int t = 0; t < 4; t++) begin
            nv[t] = 0; np[t] = 0;
            if (bv && !drop && bt == t) begin nv[t] = 1; np[t] = bp; end
            else if (macc && mt == t) begin nv[t] = 1; np[t] = ms; end
        end
        chk("R7 fwd_allow", fwd_allow, fv && !(nv[ft] && fs > np[ft]));
        hit = rv && pv[rt];
        e_susp = macc; e_act = macc; e_stid = macc ? mt : 0;
        e_next = nsp;
        for (int t = 0; t < 4; t++) begin e_sqv[t] = nv[t]; e_sqp[t] = np[t]; end
        e_rv = hit; e_rtid = hit ? rt : 0; e_ri = hit ? pi[rt] : 0; e_rs = hit ? ps[rt] : 0;
        if (hit) begin mcnt++; pv[rt] = 0; end
        if (macc) begin pv[mt] = 1; pi[mt] = mi; ps[mt] = ms; end
    endtask

    task automatic clear_inputs();
        mv = 0; rv = 0; bv = 0; fv = 0;
    endtask

    // Directed step: drive, model, then sample one cycle later.
    task automatic step();
        #1 model_step();
        @(negedge clk);
        compare_regs();
    endtask

    initial begin
        for (int t = 0; t < 4; t++) begin pv[t] = 0; pi[t] = 0; ps[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 squash_valid", sqv, 0);
        chk("R1 suspend_valid", susp, 0);
        chk("R1 reinsert_valid", reins, 0);
        chk("R1 ctx_switch_count", cnt, 0);
        chk("R1 squash_to_next", sq_next, 0);
        // R5: reactivate with empty slot
        rv = 1; rt = 2; step(); clear_inputs();
        // R2: mode off, miss ignored
        en = 0; mv = 1; mt = 1; ms = 10; mi = 32'hdead0001; step(); clear_inputs();
        rv = 1; rt = 1; step(); clear_inputs();
        // R2/R3/R9: park with mode on
        en = 1; nsp = 1; mv = 1; mt = 1; ms = 20; mi = 32'hcafe0014; step(); clear_inputs();
        // R4: reactivate returns it; then empty again
        rv = 1; rt = 1; step(); clear_inputs();
        rv = 1; rt = 1; step(); clear_inputs();
        // R6: younger duplicate stage squash dropped; R7 forwarding
        mv = 1; mt = 3; ms = 5; mi = 32'h11; bv = 1; bt = 3; bs = 9; bp = 8;
        fv = 1; ft = 3; fs = 6; step(); clear_inputs();
        // R6: older stage squash wins
        mv = 1; mt = 0; ms = 9; mi = 32'h22; bv = 1; bt = 0; bs = 4; bp = 3;
        fv = 1; ft = 0; fs = 4; nsp = 0; step(); clear_inputs();
        // R4: reactivate and re-park same thread in one cycle
        rv = 1; rt = 0; mv = 1; mt = 0; ms = 30; mi = 32'h33; step(); clear_inputs();
        rv = 1; rt = 0; step(); clear_inputs();
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            en = ($urandom_range(0, 9) != 0);
            nsp = $urandom_range(0, 1);
            mv = ($urandom_range(0, 9) < 3); mt = 2'($urandom_range(0, 3));
            ms = 16'($urandom_range(0, 15)); mi = $urandom;
            rv = ($urandom_range(0, 9) < 3); rt = 2'($urandom_range(0, 3));
            bv = ($urandom_range(0, 9) < 3); bt = 2'($urandom_range(0, 3));
            bs = 16'($urandom_range(0, 15)); bp = 16'($urandom_range(0, 15));
            fv = ($urandom_range(0, 9) < 6); ft = 2'($urandom_range(0, 3));
            fs = 16'($urandom_range(0, 15));
            step();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule